// File: doc/BRIEF.md
# Encoded-Interval Watchdog Timer

This block is a watchdog whose whole configuration is one 8-bit control register. The low two bits choose a resolution. The next five bits hold a multiplier. Together they set a timeout counted in periods of an external 16 Hz tick. The top bit chooses what the block does when the count runs out: raise an interrupt, or ask the system to reset.

Software keeps the watchdog alive by touching the register. Any write reloads the count from the new value. Any read reloads it from the value already stored. Either access also clears the timeout flag.

At expiry the flag is set. Then exactly one of two pulses is issued. With the top bit clear, the block gives an interrupt pulse. With the top bit set, it gives a reset-request pulse and, in the same cycle, a pulse that clears a control bit kept in a neighbouring register; the watchdog register itself returns to zero. After an expiry the timer stays stopped until the next restart.

Top module: `enc_wdt`

## Requirements
- R1: After reset the flag, interrupt, reset-request and side-clear outputs are 0 and the register reads 0x00.
- R2: With bits [1:0] = res and bits [6:2] = mult, the timeout fires on the (4^res × mult)-th tick after the last restart, and on no earlier tick.
- R3: A register value of 0x00 disables the watchdog: no tick ever produces a timeout.
- R4: A nonzero register whose multiplier field is 0 gives a zero interval and never times out.
- R5: A write stores the byte, restarts the count from the written value and clears the flag.
- R6: A read returns the stored byte, restarts the count from that value and clears the flag.
- R7: A timeout sets the flag one cycle after the expiring tick; the flag stays set until the next restart.
- R8: With bit 7 clear at timeout, the block issues exactly one interrupt pulse one cycle long, issues no reset request, and stays silent on later ticks.
- R9: With bit 7 set at timeout, the block issues one reset-request pulse and one side-clear pulse in the same cycle, issues no interrupt, and the register reads 0x00 afterwards.
- R10: A restart in the same cycle as the expiring tick wins: no timeout happens, and the full interval starts again.
- R11: Clock cycles without a tick do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Current register value |
| tick_i | input | 1 | One-cycle strobe at 16 Hz |
| flag_o | output | 1 | Timeout flag |
| irq_o | output | 1 | Interrupt pulse |
| rst_req_o | output | 1 | System reset request pulse |
| side_clr_o | output | 1 | Pulse that clears the neighbouring control bit |

## Verification
A restart and the tick that would end the count can arrive in the same cycle. The bench provokes this by loading a one-tick interval and then raising the read strobe and the tick together. It passes only if the flag stays clear, no pulse appears, and the next lone tick then fires the timeout. The bench also checks that an access made after a timeout clears the flag at once.

// File: rtl/enc_wdt_pkg.sv
package enc_wdt_pkg;
  localparam int REG_W     = 8;
  localparam int RES_W     = 2;
  localparam int MULT_W    = 5;
  localparam int STEER_BIT = 7;
  localparam int MAX_SHIFT = 2 * ((1 << RES_W) - 1);
  localparam int CNT_W     = MULT_W + MAX_SHIFT;
endpackage

// File: rtl/wdt_interval_dec.sv
module wdt_interval_dec
  import enc_wdt_pkg::*;
(
  input  logic [REG_W-1:0] cfg_i,
  output logic [CNT_W-1:0] ticks_o
);
  localparam int NRES = 1 << RES_W;

  logic [RES_W-1:0]  res;
  logic [MULT_W-1:0] mult;
  logic [CNT_W-1:0]  cand [NRES];

  assign res  = cfg_i[RES_W-1:0];
  assign mult = cfg_i[RES_W +: MULT_W];

  // one pre-shifted candidate per resolution step (x4 per step)
  for (genvar g = 0; g < NRES; g++) begin : g_res
    assign cand[g] = CNT_W'(mult) << (2 * g);
  end

  assign ticks_o = cand[res];
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import enc_wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             tick_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q;

  // restart has priority over a coincident tick
  assign expire_o = tick_i && !restart_i && (count_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          count_q <= '0;
    else if (restart_i)                   count_q <= load_i;
    else if (tick_i && count_q != '0)     count_q <= count_q - CNT_W'(1);
  end

  // R11
  no_drift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i) |=> $stable(count_q));

  // R10
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (count_q == $past(load_i)));
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import enc_wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             clear_i,
  output logic [REG_W-1:0] ctrl_o
);
  logic [REG_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= wdata_i;
    else if (clear_i) ctrl_q <= '0;
  end

  assign ctrl_o = ctrl_q;

  // R5
  wr_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (ctrl_o == $past(wdata_i)));
endmodule

// File: rtl/wdt_action.sv
module wdt_action (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic steer_i,
  input  logic restart_i,
  output logic flag_o,
  output logic irq_o,
  output logic rst_req_o
);
  logic flag_q, irq_q, rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      irq_q <= expire_i && !steer_i;
      rst_q <= expire_i &&  steer_i;
      if (restart_i)     flag_q <= 1'b0;
      else if (expire_i) flag_q <= 1'b1;
    end
  end

  assign flag_o    = flag_q;
  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;

  // R7
  flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> (irq_q || rst_q));

  // R8
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);

  // R5
  restart_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !flag_q);
endmodule

// File: rtl/enc_wdt.sv
module enc_wdt
  import enc_wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             tick_i,
  output logic             flag_o,
  output logic             irq_o,
  output logic             rst_req_o,
  output logic             side_clr_o
);
  logic [REG_W-1:0] ctrl;
  logic [REG_W-1:0] cfg_sel;
  logic [CNT_W-1:0] load_ticks;
  logic             restart, expire, steer_clr;

  assign restart   = wr_en_i | rd_en_i;
  assign cfg_sel   = wr_en_i ? wdata_i : ctrl;
  assign steer_clr = expire & ctrl[STEER_BIT];

  wdt_ctrl_reg u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wdata_i,
    .clear_i (steer_clr),
    .ctrl_o  (ctrl)
  );

  wdt_interval_dec u_dec (
    .cfg_i   (cfg_sel),
    .ticks_o (load_ticks)
  );

  wdt_countdown u_cnt (
    .clk_i, .rst_ni,
    .restart_i (restart),
    .load_i    (load_ticks),
    .tick_i,
    .expire_o  (expire)
  );

  wdt_action u_act (
    .clk_i, .rst_ni,
    .expire_i  (expire),
    .steer_i   (ctrl[STEER_BIT]),
    .restart_i (restart),
    .flag_o, .irq_o, .rst_req_o
  );

  assign side_clr_o = rst_req_o;
  assign rdata_o    = ctrl;

  // R8
  excl_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && rst_req_o));

  // R9
  steer_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (rdata_o == '0));

  // R3
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rdata_o) == '0 && !$past(wr_en_i)) |-> !$rose(flag_o));
endmodule

// File: tb/enc_wdt_tb.sv
module enc_wdt_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       flag, irq, rst_req, side_clr;

  int total = 0, bad = 0;
  int irq_cnt = 0, rst_cnt = 0, clr_cnt = 0;

  always #5 clk = ~clk;

  enc_wdt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .flag_o(flag),
    .irq_o(irq), .rst_req_o(rst_req), .side_clr_o(side_clr)
  );

  always @(negedge clk) begin
    if (irq)      irq_cnt++;
    if (rst_req)  rst_cnt++;
    if (side_clr) clr_cnt++;
  end

  // {write value, expected ticks} ; steer bit clear
  localparam logic [18:0] VEC [7] = '{
    {8'h04, 11'd1}, {8'h05, 11'd4}, {8'h0A, 11'd32}, {8'h0B, 11'd128},
    {8'h7C, 11'd31}, {8'h0D, 11'd12}, {8'h7F, 11'd1984}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wdata = v;
    @(negedge clk); wr_en = 1'b0; #1;
  endtask

  task automatic do_rd();
    @(negedge clk); rd_en = 1'b1;
    #1 chk(rdata == 8'h0D, "R6 rdata", rdata, 8'h0D);
    @(negedge clk); rd_en = 1'b0; #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0; #1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int i0, r0, c0;
    repeat (3) @(negedge clk);
    #1;
    // R1
    chk(flag == 0 && irq == 0 && rst_req == 0 && side_clr == 0, "R1 outs", flag, 0);
    chk(rdata == 8'h00, "R1 rdata", rdata, 0);
    rst_n = 1'b1;

    // R2 / R7 / R8 table walk
    for (int v = 0; v < 7; v++) begin
      logic [7:0] val;
      int len;
      val = VEC[v][18:11];
      len = int'(VEC[v][10:0]);
      do_wr(val);
      chk(flag == 0, "R5 flag clr", flag, 0);
      i0 = irq_cnt; r0 = rst_cnt;
      ticks(len - 1);
      chk(flag == 0 && irq_cnt == i0, "R2 early", irq_cnt - i0, 0);
      ticks(1);
      chk(flag == 1, "R7 flag set", flag, 1);
      chk(irq_cnt == i0 + 1 && rst_cnt == r0, "R8 irq once", irq_cnt - i0, 1);
      ticks(3);
      chk(irq_cnt == i0 + 1 && flag == 1, "R8 stopped", irq_cnt - i0, 1);
    end

    // R3 zero disables
    do_wr(8'h00);
    i0 = irq_cnt; r0 = rst_cnt;
    ticks(20);
    chk(flag == 0 && irq_cnt == i0 && rst_cnt == r0, "R3 off", irq_cnt - i0, 0);

    // R4 zero multiplier
    do_wr(8'h83);
    ticks(20);
    chk(flag == 0 && irq_cnt == i0 && rst_cnt == r0, "R4 mult0", rst_cnt - r0, 0);

    // R5 rewrite mid-count
    do_wr(8'h0D);
    ticks(10);
    do_wr(8'h09);
    ticks(7);
    chk(flag == 0 && irq_cnt == i0, "R5 reload", irq_cnt - i0, 0);
    ticks(1);
    chk(flag == 1 && irq_cnt == i0 + 1, "R5 new value", irq_cnt - i0, 1);

    // R6 read restarts and clears flag
    do_wr(8'h0D);
    ticks(10);
    do_rd();
    ticks(11);
    chk(flag == 0 && irq_cnt == i0 + 1, "R6 reload", irq_cnt - i0, 1);
    ticks(1);
    chk(flag == 1 && irq_cnt == i0 + 2, "R6 fire", irq_cnt - i0, 2);
    do_rd();
    chk(flag == 0, "R6 flag clr", flag, 0);

    // R9 steer to reset
    do_wr(8'h85);
    i0 = irq_cnt; r0 = rst_cnt; c0 = clr_cnt;
    ticks(4);
    chk(rst_cnt == r0 + 1 && clr_cnt == c0 + 1, "R9 pulses", rst_cnt - r0, 1);
    chk(irq_cnt == i0 && flag == 1, "R9 no irq", irq_cnt - i0, 0);
    chk(rdata == 8'h00, "R9 reg clr", rdata, 0);
    ticks(5);
    chk(rst_cnt == r0 + 1, "R9 single", rst_cnt - r0, 1);

    // R10 restart coincides with expiring tick
    do_wr(8'h04);
    i0 = irq_cnt;
    @(negedge clk); tick = 1'b1; rd_en = 1'b1;
    @(negedge clk); tick = 1'b0; rd_en = 1'b0; #1;
    @(negedge clk); #1;
    chk(flag == 0 && irq_cnt == i0, "R10 restart wins", irq_cnt - i0, 0);
    ticks(1);
    chk(flag == 1 && irq_cnt == i0 + 1, "R10 next tick", irq_cnt - i0, 1);

    // R11 idle cycles do not count
    do_wr(8'h05);
    i0 = irq_cnt;
    ticks(3);
    repeat (50) @(negedge clk);
    #1;
    chk(flag == 0 && irq_cnt == i0, "R11 idle", irq_cnt - i0, 0);
    ticks(1);
    chk(flag == 1 && irq_cnt == i0 + 1, "R11 fire", irq_cnt - i0, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule